// File: doc/BRIEF.md
# Multi-Format Video Input Demultiplexer

This block sits at the front of a triple video output path. It accepts pixel data on three 10-bit input ports and delivers, on every clock, a complete aligned triple of luma/green, blue-difference/blue and red-difference/red samples. A decoded format input selects one of three arrangements of the inputs. In full-rate 4:4:4, all three ports carry one channel each. In two-port 4:2:2, one port carries luma and a second port carries the two colour-difference components interleaved. In single-port 4:2:2, one port carries all four sample kinds in a BT.656-style interleave.

In the 4:2:2 formats the block demultiplexes samples by phase. It holds each colour-difference value until the next sample of the same component arrives, and it delays each channel by its own amount so that the samples of one triple leave together. The demultiplex phase starts again each time the active-low blanking input is released, so the first active sample always counts as a blue-difference sample. The total latency from the input register to the outputs is fixed for each format: 7, 8 or 9 clocks.

Top module: `video_fmt_demux`

## Requirements
- R1: A synchronous active-low reset clears every pipeline stage and every hold register. The next clock edge after a reset edge shows code 0 on all three outputs. The phase returns to the blue-difference state.
- R2: With fmt_sel = 0 (4:4:4), in_y, in_b and in_r are registered on every edge. They appear on out_y, out_pb and out_pr exactly 7 edges after the edge that registered them. The blanking input has no effect in this format.
- R3: With fmt_sel = 1 (two-port 4:2:2), in_y is taken on every active edge and appears on out_y 8 edges later. in_r carries blue-difference on even active positions, counted from 0 at the release, and red-difference on odd positions. These appear on out_pb after 8 edges and on out_pr after 7 edges.
- R4: With fmt_sel = 2 (single-port 4:2:2), in_y carries a repeating group of four, counted from 0 at the release: position 0 is blue-difference, positions 1 and 3 are luma, position 2 is red-difference. The latency is 9 edges for blue-difference, 8 for luma and 7 for red-difference.
- R5: In both 4:2:2 formats, the first triple after a release leaves on one edge as (red-diff(0), luma(0), blue-diff(0)). That edge is 8 (two-port) or 9 (single-port) edges after the release edge.
- R6: Every release of blanking restarts the phase. The first sample registered while blank_n is high, after a registered low, counts as blue-difference, whatever phase was reached before blanking.
- R7: Each output keeps its last value until the next sample of its own component reaches it. In single-port mode a blue-difference value stays on out_pb for 4 consecutive edges.
- R8: Ports that the selected 4:2:2 format does not use have no effect on any output. These are in_b in two-port mode, and in_b and in_r in single-port mode.
- R9: In the 4:2:2 formats, samples registered while blank_n is low are not loaded. After their channel delay the outputs keep the values of the last active samples.
- R10: fmt_sel = 3 behaves exactly as 4:4:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Input format: 0 = 4:4:4, 1 = two-port 4:2:2, 2 = single-port 4:2:2, 3 = same as 0 |
| blank_n | input | 1 | Blanking, active low; a rise restarts the 4:2:2 phase |
| in_y | input | 10 | Luma/green port; the whole stream in single-port mode |
| in_b | input | 10 | Blue/blue-difference port (4:4:4 only) |
| in_r | input | 10 | Red/red-difference port; the interleaved colour-difference stream in two-port mode |
| out_y | output | 10 | Aligned luma/green sample |
| out_pb | output | 10 | Aligned blue-difference/blue sample |
| out_pr | output | 10 | Aligned red-difference/red sample |

## Verification
A phase counter that is off by one swaps the roles of samples. That error reaches the ports 7 to 9 edges after the release that should have restarted it. The outputs show luma on a colour-difference channel, or red-difference and blue-difference exchanged, for the whole active line. A wrong channel tap shows as a triple in which one component is one or two samples early or late. This is visible on the first triple after a release. A hold register that loads during blanking shows as an output that changes inside a blanked stretch, one channel latency after the blank edge.

// File: rtl/vdx_pkg.sv
package vdx_pkg;

  typedef enum logic [1:0] {
    FMT_444    = 2'd0,
    FMT_422_2P = 2'd1,
    FMT_422_1P = 2'd2,
    FMT_ALT444 = 2'd3
  } fmt_e;

  localparam logic [1:0] PH_PB = 2'd0;
  localparam logic [1:0] PH_YA = 2'd1;
  localparam logic [1:0] PH_PR = 2'd2;
  localparam logic [1:0] PH_YB = 2'd3;

  localparam int CH_Y  = 0;
  localparam int CH_PB = 1;
  localparam int CH_PR = 2;
  localparam int NCH   = 3;

  function automatic logic is_sub(fmt_e f);
    return (f == FMT_422_2P) || (f == FMT_422_1P);
  endfunction

  // phase of the sample registered at the next edge
  function automatic logic [1:0] phase_after(logic [1:0] ph, logic incoming, logic current);
    return (incoming && current) ? ph + 2'd1 : PH_PB;
  endfunction

  // latency from input register to output, per channel
  function automatic int chan_lat(fmt_e f, int ch, int base);
    int extra;
    extra = 0;
    if (ch == CH_Y && is_sub(f)) extra = 1;
    if (ch == CH_PB && f == FMT_422_2P) extra = 1;
    if (ch == CH_PB && f == FMT_422_1P) extra = 2;
    return base + extra;
  endfunction

endpackage

// File: rtl/vdx_capture.sv
module vdx_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blank_n,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] y_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] r_q,
  output logic         act_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q   <= '0;
      b_q   <= '0;
      r_q   <= '0;
      act_q <= 1'b0;
    end else begin
      y_q   <= in_y;
      b_q   <= in_b;
      r_q   <= in_r;
      act_q <= blank_n;
    end
  end
endmodule

// File: rtl/vdx_sequencer.sv
module vdx_sequencer import vdx_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blank_n,
  input  logic       act_q,
  output logic [1:0] ph
);
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_PB;
    else        ph <= phase_after(ph, blank_n, act_q);
  end

  // R6: first active sample after a release is blue-difference
  p_phase_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (ph == PH_PB));

  // R4: consecutive active samples step through the group of four
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (ph == $past(ph) + 2'd1));
endmodule

// File: rtl/vdx_router.sv
module vdx_router import vdx_pkg::*; #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fmt_e         fmt,
  input  logic         act_q,
  input  logic [1:0]   ph,
  input  logic [W-1:0] y_q,
  input  logic [W-1:0] b_q,
  input  logic [W-1:0] r_q,
  output logic [W-1:0] h_y,
  output logic [W-1:0] h_pb,
  output logic [W-1:0] h_pr
);
  logic         ld_y, ld_pb, ld_pr;
  logic [W-1:0] src_pb, src_pr;
  logic         sub;

  assign sub = is_sub(fmt);

  always_comb begin
    ld_y   = 1'b1;
    ld_pb  = 1'b1;
    ld_pr  = 1'b1;
    src_pb = b_q;
    src_pr = r_q;
    case (fmt)
      FMT_422_2P: begin
        ld_y   = act_q;
        ld_pb  = act_q && !ph[0];
        ld_pr  = act_q && ph[0];
        src_pb = r_q;
        src_pr = r_q;
      end
      FMT_422_1P: begin
        ld_y   = act_q && ph[0];
        ld_pb  = act_q && (ph == PH_PB);
        ld_pr  = act_q && (ph == PH_PR);
        src_pb = y_q;
        src_pr = y_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_y  <= '0;
      h_pb <= '0;
      h_pr <= '0;
    end else begin
      if (ld_y)  h_y  <= y_q;
      if (ld_pb) h_pb <= src_pb;
      if (ld_pr) h_pr <= src_pr;
    end
  end

  // R3: a colour-difference sample never loads both components
  p_chroma_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sub |-> !(ld_pb && ld_pr));

  // R4: in single-port mode a luma slot carries no colour-difference
  p_luma_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FMT_422_1P && ld_y) |-> (!ld_pb && !ld_pr));

  // R9: blanked samples leave every hold register unchanged
  p_blank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && !act_q && $stable(fmt)) |=> ($stable(h_y) && $stable(h_pb) && $stable(h_pr)));
endmodule

// File: rtl/vdx_delay.sv
module vdx_delay #(
  parameter int W     = 10,
  parameter int DEPTH = 8,
  parameter int SELW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    d,
  input  logic [SELW-1:0] sel,
  output logic [W-1:0]    q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = (int'(sel) < DEPTH) ? stage[sel] : stage[DEPTH-1];
endmodule

// File: rtl/video_fmt_demux.sv
module video_fmt_demux import vdx_pkg::*; #(
  parameter int W        = 10,
  parameter int BASE_LAT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   fmt_sel,
  input  logic         blank_n,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] out_y,
  output logic [W-1:0] out_pb,
  output logic [W-1:0] out_pr
);
  localparam int DEPTH = BASE_LAT + 1;
  localparam int SELW  = $clog2(DEPTH);

  fmt_e         fmt;
  logic [W-1:0] y_q, b_q, r_q;
  logic         act_q;
  logic [1:0]   ph;
  logic [W-1:0] h_y, h_pb, h_pr;
  logic [W-1:0] hold [NCH];
  logic [W-1:0] tap  [NCH];

  assign fmt = fmt_e'(fmt_sel);

  vdx_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n),
    .in_y(in_y), .in_b(in_b), .in_r(in_r),
    .y_q(y_q), .b_q(b_q), .r_q(r_q), .act_q(act_q)
  );

  vdx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .act_q(act_q), .ph(ph)
  );

  vdx_router #(.W(W)) u_rt (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .act_q(act_q), .ph(ph),
    .y_q(y_q), .b_q(b_q), .r_q(r_q),
    .h_y(h_y), .h_pb(h_pb), .h_pr(h_pr)
  );

  assign hold[CH_Y]  = h_y;
  assign hold[CH_PB] = h_pb;
  assign hold[CH_PR] = h_pr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SELW-1:0] sel;
    // capture and hold stages account for two of the clocks
    assign sel = SELW'(chan_lat(fmt, c, BASE_LAT) - 2);
    vdx_delay #(.W(W), .DEPTH(DEPTH)) u_dl (
      .clk(clk), .rst_n(rst_n), .d(hold[c]), .sel(sel), .q(tap[c])
    );
  end

  assign out_y  = tap[CH_Y];
  assign out_pb = tap[CH_PB];
  assign out_pr = tap[CH_PR];

  // R1: a reset edge leaves code 0 on all outputs
  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (out_y == '0 && out_pb == '0 && out_pr == '0));
endmodule

// File: tb/sim_video_fmt_demux.sv
`timescale 1ns/1ps
module sim_video_fmt_demux;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   fmt_sel = 2'd0;
  logic         blank_n = 1'b0;
  logic [W-1:0] in_y = '0, in_b = '0, in_r = '0;
  logic [W-1:0] out_y, out_pb, out_pr;

  always #4 clk = ~clk;

  video_fmt_demux u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .blank_n(blank_n),
    .in_y(in_y), .in_b(in_b), .in_r(in_r),
    .out_y(out_y), .out_pb(out_pb), .out_pr(out_pr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] sy [64], sb [64], sr [64];
  logic         sbl [64];
  logic         rp [64], ry [64], rr [64];
  logic [W-1:0] vp [64], vy [64], vr [64];
  logic [W-1:0] oy [64], op [64], orr [64];

  task automatic chk(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic fill(input int sdy, input int sdb, input int sdr, input int n);
    for (int k = 0; k < n; k++) begin
      sy[k] = W'((k * 41 + sdy * 7 + 3) % 1024);
      sb[k] = W'((k * 173 + sdb * 11 + 9) % 1024);
      sr[k] = W'((k * 89 + sdr * 13 + 17) % 1024);
      sbl[k] = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; blank_n = 1'b0;
    in_y = '0; in_b = '0; in_r = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [1:0] m, input int n);
    fmt_sel = m;
    do_reset();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) begin oy[k-1] = out_y; op[k-1] = out_pb; orr[k-1] = out_pr; end
      rst_n = 1'b1;
      in_y = sy[k]; in_b = sb[k]; in_r = sr[k]; blank_n = sbl[k];
    end
    @(negedge clk);
    oy[n-1] = out_y; op[n-1] = out_pb; orr[n-1] = out_pr;
  endtask

  // sample roles from the format rules of R2/R3/R4/R6/R9/R10
  task automatic build(input logic [1:0] m, input int n);
    int pos;
    pos = 0;
    for (int k = 0; k < n; k++) begin
      rp[k] = 0; ry[k] = 0; rr[k] = 0;
      if (m == 2'd1 || m == 2'd2) begin
        if (!sbl[k]) pos = 0;
        else begin
          if (m == 2'd1) begin
            ry[k] = 1; vy[k] = sy[k];
            if (pos % 2 == 0) begin rp[k] = 1; vp[k] = sr[k]; end
            else begin rr[k] = 1; vr[k] = sr[k]; end
          end else begin
            case (pos % 4)
              0: begin rp[k] = 1; vp[k] = sy[k]; end
              2: begin rr[k] = 1; vr[k] = sy[k]; end
              default: begin ry[k] = 1; vy[k] = sy[k]; end
            endcase
          end
          pos++;
        end
      end else begin
        rp[k] = 1; ry[k] = 1; rr[k] = 1;
        vp[k] = sb[k]; vy[k] = sy[k]; vr[k] = sr[k];
      end
    end
  endtask

  function automatic logic [W-1:0] expect_at(input int ch, input logic [1:0] m, input int j);
    int lat;
    lat = 7;
    if (ch == 0 && (m == 2'd1 || m == 2'd2)) lat = 8;
    if (ch == 1 && m == 2'd1) lat = 8;
    if (ch == 1 && m == 2'd2) lat = 9;
    for (int k = j - lat; k >= 0; k--) begin
      if (ch == 0 && ry[k]) return vy[k];
      if (ch == 1 && rp[k]) return vp[k];
      if (ch == 2 && rr[k]) return vr[k];
    end
    return '0;
  endfunction

  task automatic compare(input string tag, input logic [1:0] m, input int n);
    for (int j = 0; j < n; j++) begin
      chk(tag, $sformatf("out_y@%0d", j),  oy[j],  expect_at(0, m, j));
      chk(tag, $sformatf("out_pb@%0d", j), op[j],  expect_at(1, m, j));
      chk(tag, $sformatf("out_pr@%0d", j), orr[j], expect_at(2, m, j));
    end
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1", "out_y after reset", out_y, '0);
    chk("R1", "out_pb after reset", out_pb, '0);
    chk("R1", "out_pr after reset", out_pr, '0);
  endtask

  task automatic t_full_r2();
    fill(1, 2, 3, 40);
    for (int k = 0; k < 40; k++) sbl[k] = (k % 7 != 3);
    build(2'd0, 40); run(2'd0, 40); compare("R2", 2'd0, 40);
  endtask

  task automatic t_alt_r10();
    fill(4, 5, 6, 30);
    for (int k = 0; k < 30; k++) sbl[k] = (k % 5 != 1);
    build(2'd3, 30); run(2'd3, 30); compare("R10", 2'd3, 30);
  endtask

  task automatic t_two_r3();
    fill(7, 8, 9, 40);
    for (int k = 0; k < 40; k++) sbl[k] = !(k < 3 || (k >= 20 && k <= 22));
    build(2'd1, 40); run(2'd1, 40); compare("R3", 2'd1, 40);
    chk("R5", "two-port first triple pb", op[11], sr[3]);
    chk("R5", "two-port first triple y", oy[11], sy[3]);
    chk("R5", "two-port first triple pr", orr[11], sr[4]);
  endtask

  task automatic t_one_r4();
    fill(10, 11, 12, 44);
    for (int k = 0; k < 44; k++) sbl[k] = !(k < 2 || (k >= 24 && k <= 26));
    build(2'd2, 44); run(2'd2, 44); compare("R4", 2'd2, 44);
    chk("R5", "one-port first triple pb", op[11], sy[2]);
    chk("R5", "one-port first triple y", oy[11], sy[3]);
    chk("R5", "one-port first triple pr", orr[11], sy[4]);
    for (int j = 11; j <= 14; j++) chk("R7", $sformatf("pb held @%0d", j), op[j], sy[2]);
    chk("R7", "next pb sample", op[15], sy[6]);
    chk("R6", "pb after re-release", op[36], sy[27]);
    chk("R6", "y after re-release", oy[36], sy[28]);
    chk("R6", "pr after re-release", orr[36], sy[29]);
  endtask

  task automatic t_unused_r8();
    fill(13, 14, 15, 36);
    for (int k = 0; k < 36; k++) begin
      sb[k] = (k % 2 == 0) ? 10'h3FF : 10'h000;
      sbl[k] = (k >= 1);
    end
    build(2'd1, 36); run(2'd1, 36); compare("R8", 2'd1, 36);
    for (int k = 0; k < 36; k++) sr[k] = 10'h2AA ^ W'(k);
    build(2'd2, 36); run(2'd2, 36); compare("R8", 2'd2, 36);
  endtask

  task automatic t_blank_r9();
    fill(16, 17, 18, 40);
    for (int k = 0; k < 40; k++) sbl[k] = !(k < 3 || (k >= 15 && k <= 24));
    build(2'd1, 40); run(2'd1, 40); compare("R9", 2'd1, 40);
    chk("R9", "pb frozen in blank", op[30], sr[13]);
    chk("R9", "pr frozen in blank", orr[30], sr[14]);
    chk("R9", "y frozen in blank", oy[30], sy[14]);
  endtask

  initial begin
    t_reset_r1();
    t_full_r2();
    t_reset_r1();
    t_alt_r10();
    t_two_r3();
    t_one_r4();
    t_unused_r8();
    t_blank_r9();
    t_reset_r1();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule